// File: doc/BRIEF.md
# Alternating-Field Interlace Sync Generator

This block derives horizontal and vertical sync timing from a clock running at the colour-clock rate. It keeps a column counter and a line counter. With interlace off, it produces the plain progressive raster: 228 clocks per line, 262 lines per field, and vertical sync aligned to a line edge in every field. Broadcast interlaced video uses 227.5 clocks per line and 262.5 lines per field, and two fields make a frame. The block approximates that by offsetting alternate fields by half a line.

A single software-written bit turns interlace on. While interlace is on, the generator alternates between two kinds of field:

- **Offset field:** vertical sync starts halfway through the last scanline of the previous field, and the horizontal pulse at the next line edge is cancelled.
- **Aligned field:** vertical sync starts together with horizontal sync on a line edge.

A parity flag reports which kind of field is running. The counters are exported so that pixel logic further down can follow the raster.

Line length, field length, pulse width and vertical sync length are parameters. The defaults are 228, 262, 16 and 3. The half-line point is half the line length, which is 114 by default.

Top module: `isync_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the column and line counts read 0, the parity flag reads 0, and both hsync and vsync are high.
- R2: The column count steps by one on every clock from 0 to LINE_CLKS-1 (227) and then wraps to 0. The line count steps by one at each column wrap from 0 to FIELD_LINES-1 (261) and then wraps to 0.
- R3: hsync is high for column counts 0 to HS_WIDTH-1 (0 to 15) of every line and low otherwise, except in the case given by R7.
- R4: In a field whose sync was chosen with the enable clear, vsync is high for exactly lines 0 to VS_LINES-1 (lines 0, 1 and 2, whole lines). It rises at column 0 of line 0 and falls at column 0 of line VS_LINES.
- R5: The enable bit is sampled only on the clock where the column count is 0 and the line count is FIELD_LINES-1. A change of the enable at any other time has no effect on the next vertical sync.
- R6: If the sampled enable is 1 and the parity flag is 0, vsync rises at column LINE_CLKS/2 (114) of line FIELD_LINES-1. It stays high for VS_LINES line periods (684 clocks by default) and falls at column LINE_CLKS/2 of line VS_LINES-1 of the following field.
- R7: In the field that follows an R6 start, hsync stays low for the whole of line 0, columns 0 to HS_WIDTH-1.
- R8: On the clock after each vsync rise, the parity flag becomes the inverse of its old value if the sampled enable is 1, and becomes 0 if it is 0. It changes at no other time. With the sampled enable at 1 and the parity flag at 1, vsync starts on a line edge as in R4.
- R9: After the enable has been sampled as 0, the following field's timing is identical to the timing with interlace never enabled, and the parity flag is 0 from the clock after that field's vsync rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Colour-clock-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ilace_en_i | input | 1 | Software-written interlace enable |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| field_o | output | 1 | Field parity: 1 while in an offset field |
| hcnt_o | output | HW (8) | Column count within the line |
| vcnt_o | output | VW (9) | Line count within the field |

## Verification
The hardest situation to reach is a change of the enable that arrives after the sample point on the final line but before the mid-line sync start. A design that samples late would move that sync, but only thousands of clocks into a field.

To make many such fields affordable, the bench runs the block with a short line and a short field. It sets the enable one line before the sample point, then inverts it a few clocks after the sample point in every field. The expected sync edges follow the value set first.

The run walks the parity flag through both kinds of field in a row. It then disables interlace while the flag is 1, and once more while the flag is 0.

// File: rtl/isync_pkg.sv
package isync_pkg;

    localparam int DEF_LINE_CLKS   = 228;
    localparam int DEF_FIELD_LINES = 262;
    localparam int DEF_HS_WIDTH    = 16;
    localparam int DEF_VS_LINES    = 3;

    // where the next vertical sync begins
    typedef enum logic {
        VS_EDGE = 1'b0,   // column 0 of line 0
        VS_MID  = 1'b1    // half-line point of the last line
    } vs_mode_e;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic vs_start;
    } sync_t;

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/isync_timebase.sv
module isync_timebase
    import isync_pkg::*;
#(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int FIELD_LINES = DEF_FIELD_LINES,
    parameter int HW          = cnt_width(DEF_LINE_CLKS),
    parameter int VW          = cnt_width(DEF_FIELD_LINES)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o,
    output logic          at_latch_o
);

    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(FIELD_LINES - 1);

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_q == H_LAST) begin
            h_q <= '0;
            v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign hcnt_o     = h_q;
    assign vcnt_o     = v_q;
    // first clock of the final line: enable sample point
    assign at_latch_o = (h_q == '0) && (v_q == V_LAST);

endmodule

// File: rtl/isync_field_ctrl.sv
module isync_field_ctrl
    import isync_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     ilace_en_i,
    input  logic     at_latch_i,
    input  logic     vs_start_i,
    output vs_mode_e mode_o,
    output logic     field_o
);

    logic     en_q;
    logic     field_q;
    vs_mode_e mode_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q   <= 1'b0;
            mode_q <= VS_EDGE;
        end else if (at_latch_i) begin
            en_q   <= ilace_en_i;
            mode_q <= (ilace_en_i && !field_q) ? VS_MID : VS_EDGE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            field_q <= 1'b0;
        end else if (vs_start_i) begin
            field_q <= en_q ? ~field_q : 1'b0;
        end
    end

    assign mode_o  = mode_q;
    assign field_o = field_q;

endmodule

// File: rtl/isync_decode.sv
module isync_decode
    import isync_pkg::*;
#(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int FIELD_LINES = DEF_FIELD_LINES,
    parameter int HS_WIDTH    = DEF_HS_WIDTH,
    parameter int VS_LINES    = DEF_VS_LINES,
    parameter int HW          = cnt_width(DEF_LINE_CLKS),
    parameter int VW          = cnt_width(DEF_FIELD_LINES)
) (
    input  logic [HW-1:0] hcnt_i,
    input  logic [VW-1:0] vcnt_i,
    input  vs_mode_e      mode_i,
    output sync_t         sync_o
);

    localparam logic [HW-1:0] H_HALF  = HW'(LINE_CLKS / 2);
    localparam logic [HW-1:0] H_PULSE = HW'(HS_WIDTH);
    localparam logic [VW-1:0] V_LAST  = VW'(FIELD_LINES - 1);
    localparam logic [VW-1:0] V_EDGE  = VW'(VS_LINES);
    localparam logic [VW-1:0] V_MIDLN = VW'(VS_LINES - 1);

    logic edge_win, mid_win, pulse_win, cut_pulse;

    always_comb begin
        edge_win  = (vcnt_i < V_EDGE);
        mid_win   = ((vcnt_i == V_LAST) && (hcnt_i >= H_HALF))
                  || (vcnt_i < V_MIDLN)
                  || ((vcnt_i == V_MIDLN) && (hcnt_i < H_HALF));
        pulse_win = (hcnt_i < H_PULSE);
        cut_pulse = (mode_i == VS_MID) && (vcnt_i == '0);

        sync_o.hsync    = pulse_win && !cut_pulse;
        sync_o.vsync    = (mode_i == VS_MID) ? mid_win : edge_win;
        sync_o.vs_start = (mode_i == VS_MID)
                        ? ((vcnt_i == V_LAST) && (hcnt_i == H_HALF))
                        : ((vcnt_i == '0) && (hcnt_i == '0));
    end

endmodule

// File: rtl/isync_gen.sv
module isync_gen
    import isync_pkg::*;
#(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int FIELD_LINES = DEF_FIELD_LINES,
    parameter int HS_WIDTH    = DEF_HS_WIDTH,
    parameter int VS_LINES    = DEF_VS_LINES,
    parameter int HW          = cnt_width(LINE_CLKS),
    parameter int VW          = cnt_width(FIELD_LINES)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ilace_en_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          field_o,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o
);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          at_latch;
    vs_mode_e      mode;
    sync_t         sync;

    isync_timebase #(
        .LINE_CLKS  (LINE_CLKS),
        .FIELD_LINES(FIELD_LINES),
        .HW         (HW),
        .VW         (VW)
    ) u_tb (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hcnt_o    (hcnt),
        .vcnt_o    (vcnt),
        .at_latch_o(at_latch)
    );

    isync_field_ctrl u_fc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ilace_en_i(ilace_en_i),
        .at_latch_i(at_latch),
        .vs_start_i(sync.vs_start),
        .mode_o    (mode),
        .field_o   (field_o)
    );

    isync_decode #(
        .LINE_CLKS  (LINE_CLKS),
        .FIELD_LINES(FIELD_LINES),
        .HS_WIDTH   (HS_WIDTH),
        .VS_LINES   (VS_LINES),
        .HW         (HW),
        .VW         (VW)
    ) u_dec (
        .hcnt_i(hcnt),
        .vcnt_i(vcnt),
        .mode_i(mode),
        .sync_o(sync)
    );

    assign hsync_o = sync.hsync;
    assign vsync_o = sync.vsync;
    assign hcnt_o  = hcnt;
    assign vcnt_o  = vcnt;

endmodule

// File: rtl/isync_checker.sv
module isync_checker #(
    parameter int LINE_CLKS   = 228,
    parameter int FIELD_LINES = 262,
    parameter int HS_WIDTH    = 16,
    parameter int HW          = 8,
    parameter int VW          = 9
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          field_o,
    input logic [HW-1:0] hcnt_o,
    input logic [VW-1:0] vcnt_o
);

    localparam logic [HW-1:0] C_LAST  = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] C_HALF  = HW'(LINE_CLKS / 2);
    localparam logic [HW-1:0] C_PULSE = HW'(HS_WIDTH);
    localparam logic [VW-1:0] L_LAST  = VW'(FIELD_LINES - 1);

    logic vs_d1, vs_d2;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vs_d1 <= 1'b0;
            vs_d2 <= 1'b0;
        end else begin
            vs_d1 <= vsync_o;
            vs_d2 <= vs_d1;
        end
    end

    AST_COL_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        hcnt_o == C_LAST |=> hcnt_o == '0);                                      // R2

    AST_HS_RISE_COL0: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hsync_o) |-> hcnt_o == '0);                                        // R3

    AST_HS_FALL_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hsync_o) |-> hcnt_o == C_PULSE);                                   // R3

    AST_VS_START_POS: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(vsync_o) |-> ((hcnt_o == '0) && (vcnt_o == '0))
                        || ((hcnt_o == C_HALF) && (vcnt_o == L_LAST)));          // R6

    AST_HS_CUT_OFFSET: assert property (@(posedge clk_i) disable iff (rst_i)
        (hcnt_o == '0) && (vcnt_o == '0) && vs_d1 |-> !hsync_o);                 // R7

    AST_FIELD_ONLY_AFTER_START: assert property (@(posedge clk_i) disable iff (rst_i)
        (field_o != $past(field_o)) |-> (vs_d1 && !vs_d2));                      // R8

endmodule

bind isync_gen isync_checker #(
    .LINE_CLKS  (LINE_CLKS),
    .FIELD_LINES(FIELD_LINES),
    .HS_WIDTH   (HS_WIDTH),
    .HW         (HW),
    .VW         (VW)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hsync_o(hsync_o),
    .vsync_o(vsync_o),
    .field_o(field_o),
    .hcnt_o (hcnt_o),
    .vcnt_o (vcnt_o)
);

// File: tb/tb_isync_gen.sv
module tb_isync_gen;

    localparam int L    = 40;
    localparam int N    = 12;
    localparam int HSW  = 4;
    localparam int VSL  = 3;
    localparam int HALF = L / 2;
    localparam int HW   = $clog2(L);
    localparam int VW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          hsync, vsync, field;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    always #2.5 clk = ~clk;

    isync_gen #(
        .LINE_CLKS  (L),
        .FIELD_LINES(N),
        .HS_WIDTH   (HSW),
        .VS_LINES   (VSL)
    ) dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .ilace_en_i(en),
        .hsync_o   (hsync),
        .vsync_o   (vsync),
        .field_o   (field),
        .hcnt_o    (hcnt),
        .vcnt_o    (vcnt)
    );

    typedef struct {
        bit rise;
        int h;
        int v;
        int fld;
    } ev_t;

    ev_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    bit  mon_on = 1'b0;
    bit  done   = 1'b0;
    bit  exp_offset = 1'b0;
    int  exp_field  = 0;
    int  prev_h = 0, prev_v = 0;
    bit  prev_vs = 1'b1;

    task automatic chk(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
        end
    endtask

    // driver: pushes the sync edges expected for the coming field boundary
    task automatic push_field(input bit en_set);
        ev_t r, f;
        while (!(int'(vcnt) == N - 2 && hcnt == '0)) @(negedge clk);
        en = en_set;
        if (en_set && exp_field == 0) begin
            r = '{1'b1, HALF, N - 1, 0};
            f = '{1'b0, HALF, VSL - 1, 1};
            exp_field  = 1;
            exp_offset = 1'b1;
        end else begin
            r = '{1'b1, 0, 0, 0};
            f = '{1'b0, 0, VSL, en_set ? 1 - exp_field : 0};
            exp_field  = f.fld;
            exp_offset = 1'b0;
        end
        exp_q.push_back(r);
        exp_q.push_back(f);
        // R5: flip the enable just after the sample point; no effect expected
        while (!(int'(vcnt) == N - 1 && int'(hcnt) == 3)) @(negedge clk);
        en = ~en_set;
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            ev_t e;
            int  hs_exp;
            if (prev_h == L - 1) begin
                chk("R2", int'(hcnt), 0, "column wrap");
                chk("R2", int'(vcnt), (prev_v == N - 1) ? 0 : prev_v + 1, "line step");
            end else begin
                chk("R2", int'(hcnt), prev_h + 1, "column step");
            end
            if (hcnt == '0 || int'(hcnt) == HSW - 1) begin
                hs_exp = (vcnt == '0 && exp_offset) ? 0 : 1;
                chk((hs_exp == 0) ? "R7" : "R3", int'(hsync), hs_exp, "hsync in pulse window");
            end else if (int'(hcnt) == HSW) begin
                chk("R3", int'(hsync), 0, "hsync after pulse");
            end
            if (vsync != prev_vs) begin
                if (exp_q.size() == 0) begin
                    chk("R4", 1, 0, "unexpected vsync edge");
                end else begin
                    e = exp_q.pop_front();
                    chk("R6", int'(vsync), int'(e.rise), "vsync edge polarity");
                    chk("R4", int'(hcnt), e.h, "vsync edge column");
                    chk("R6", int'(vcnt), e.v, "vsync edge line");
                    if (!e.rise) chk("R8", int'(field), e.fld, "parity after start");
                end
            end
            prev_h  = int'(hcnt);
            prev_v  = int'(vcnt);
            prev_vs = vsync;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk("R1", int'(hcnt), 0, "reset column");
        chk("R1", int'(vcnt), 0, "reset line");
        chk("R1", int'(field), 0, "reset parity");
        chk("R1", int'(hsync), 1, "reset hsync");
        chk("R1", int'(vsync), 1, "reset vsync");
        rst = 1'b0;
        #1;
        chk("R1", int'(hcnt), 0, "column after release");
        exp_q.push_back('{1'b0, 0, VSL, 0});   // R4: first field falls on a line edge
        mon_on = 1'b1;
        push_field(1'b1);   // R6 offset field
        push_field(1'b1);   // R8 aligned field, parity back to 0
        push_field(1'b1);
        push_field(1'b1);
        push_field(1'b0);   // R9 disabled with parity 0
        push_field(1'b0);
        push_field(1'b1);
        push_field(1'b0);   // R9 disabled while parity 1
        while (!(int'(vcnt) == VSL + 1 && hcnt == '0)) @(negedge clk);
        chk("R8", exp_q.size(), 0, "pending vsync edges");
        chk("R9", int'(field), 0, "parity after disable");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule